// File: doc/BRIEF.md
# Scanline Window Compare Event

This block watches the scanline number coming from a display timing generator and raises a single-cycle event when the scan enters a window set by software. The window is set by two compare registers. One holds the lower bound and the enable. The other holds the upper bound. Software usually puts the upper bound at the line where vertical blank begins, minus the time in lines that the downstream work needs. It puts the lower bound two lines below that. The event then gives the consumer a fixed head start before blanking. The consumer might, for example, be a sequencer that applies a queued flip.

The event fires at most once per frame. The frame-start strobe arms it again. A sticky status bit records that an event occurred. Software clears that bit by writing a one to it. Reset clears both compare registers, which leaves the comparison disabled. Writing zero to both registers has the same effect.

Top module: `scanline_window_event`

## Requirements
- R1: After reset, `event_o` and `status_o` are 0, and both compare registers read as zero with the enable clear, so no event occurs until software programs them.
- R2: A write to address 0 loads the lower bound from `wr_data_i[15:0]` and the enable from `wr_data_i[31]`. A write to address 1 loads the upper bound from `wr_data_i[15:0]`.
- R3: When the enable is set and the sampled scanline satisfies lower <= scanline <= upper, with both bounds inclusive, and the block is armed, `event_o` is high for exactly the one cycle after that sampling edge.
- R4: After an event, the block gives no further event while the scanline stays in the window, until a frame-start strobe arrives.
- R5: A high `frame_start_i` re-arms the block. If the scanline sampled together with the strobe lies in the window, the event fires for that same sample.
- R6: While the enable bit is 0, no event is produced for any scanline.
- R7: When the lower bound is greater than the upper bound, the window is empty and no event is produced.
- R8: `status_o` goes to 1 in the same cycle as the event and stays 1. A write to address 2 with bit 0 set clears it. A write to address 2 with bit 0 clear leaves it unchanged.
- R9: If an event and a status-clear write fall on the same edge, the status ends up set.
- R10: A write to address 3 changes neither bound nor the enable.
- R11: A register write takes effect from the sample at the next edge. The sample taken at the edge of the write itself still uses the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 lower/enable, 1 upper, 2 status clear) |
| wr_data_i | input | 32 | Register write data |
| scanline_i | input | 16 | Current scanline from the timing generator |
| frame_start_i | input | 1 | Frame-start strobe that re-arms the event |
| event_o | output | 1 | Single-cycle window-entry event |
| status_o | output | 1 | Sticky record that an event occurred |

## Verification
Two of the block's jobs can land on the same edge. An entry into the window can set the sticky status while software is clearing that status by write. The frame-start re-arm can also arrive on the very sample that lies in the window. The bench provokes both at once. It drives the frame-start strobe, an in-window scanline and a clear write to address 2 in one cycle. It judges the result at the ports: the event must pulse and the status must stay set. A later clear write with no event must then bring the status to 0.

// File: rtl/scw_pkg.sv
package scw_pkg;
  localparam int unsigned SCW_ADDR_W = 2;

  typedef enum logic [SCW_ADDR_W-1:0] {
    SCW_LOWER  = 2'd0,
    SCW_UPPER  = 2'd1,
    SCW_STATUS = 2'd2,
    SCW_SPARE  = 2'd3
  } scw_addr_e;
endpackage

// File: rtl/scw_regs.sv
module scw_regs
  import scw_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SL_W   = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  wr_en_i,
  input  logic [SCW_ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [SL_W-1:0]       lo_bound_o,
  output logic [SL_W-1:0]       hi_bound_o,
  output logic                  cmp_en_o,
  output logic                  clr_req_o
);
  localparam int unsigned EN_POS = DATA_W - 1;

  scw_addr_e sel;
  assign sel = scw_addr_e'(wr_addr_i);

  logic [SL_W-1:0] lo_q, hi_q;
  logic            en_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lo_q <= '0;
      hi_q <= '0;
      en_q <= 1'b0;
    end else if (wr_en_i) begin
      case (sel)
        SCW_LOWER: begin
          lo_q <= wr_data_i[SL_W-1:0];
          en_q <= wr_data_i[EN_POS];
        end
        SCW_UPPER: hi_q <= wr_data_i[SL_W-1:0];
        default: ;
      endcase
    end
  end

  assign clr_req_o  = wr_en_i && (sel == SCW_STATUS) && wr_data_i[0];
  assign lo_bound_o = lo_q;
  assign hi_bound_o = hi_q;
  assign cmp_en_o   = en_q;

  logic unused_data;
  assign unused_data = ^wr_data_i[EN_POS-1:SL_W];

  // R10: the spare address leaves the window configuration untouched
  assert_spare_ignored_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_addr_i == 2'd3) |=> ($stable(lo_q) && $stable(hi_q) && $stable(en_q)));

  // R2: an upper-bound write lands in the upper field only
  assert_upper_load_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_addr_i == 2'd1) |=> (hi_q == $past(wr_data_i[SL_W-1:0]) && $stable(lo_q)));
endmodule

// File: rtl/scw_compare.sv
module scw_compare #(
  parameter int unsigned SL_W = 16
) (
  input  logic [SL_W-1:0] scanline_i,
  input  logic [SL_W-1:0] lo_bound_i,
  input  logic [SL_W-1:0] hi_bound_i,
  input  logic            cmp_en_i,
  output logic            hit_o
);
  logic above_lo, below_hi;

  always_comb begin
    above_lo = (scanline_i >= lo_bound_i);
    below_hi = (scanline_i <= hi_bound_i);
    hit_o    = cmp_en_i && above_lo && below_hi;
  end
endmodule

// File: rtl/scw_event.sv
module scw_event (
  input  logic clk_i,
  input  logic rst_i,
  input  logic hit_i,
  input  logic frame_start_i,
  input  logic clr_req_i,
  output logic event_o,
  output logic status_o
);
  logic armed_q, event_q, status_q;
  logic fire;

  assign fire = hit_i && (armed_q || frame_start_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      armed_q  <= 1'b1;
      event_q  <= 1'b0;
      status_q <= 1'b0;
    end else begin
      event_q <= fire;
      if (fire)               armed_q <= 1'b0;
      else if (frame_start_i) armed_q <= 1'b1;
      if (fire)               status_q <= 1'b1;
      else if (clr_req_i)     status_q <= 1'b0;
    end
  end

  assign event_o  = event_q;
  assign status_o = status_q;

  // R4: without a new frame strobe, a pulse is never followed by another
  assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (event_q && !frame_start_i) |=> !event_q);

  // R8: the sticky bit is present whenever the event is
  assert_status_with_event_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    event_q |-> status_q);

  // R8: a clear without a coinciding event drops the status
  assert_clear_effect_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_req_i && !hit_i) |=> !status_q);

  // R9: an event beats a simultaneous clear
  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_req_i && hit_i && frame_start_i) |=> (status_q && event_q));
endmodule

// File: rtl/scanline_window_event.sv
module scanline_window_event
  import scw_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SL_W   = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  wr_en_i,
  input  logic [SCW_ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic [SL_W-1:0]       scanline_i,
  input  logic                  frame_start_i,
  output logic                  event_o,
  output logic                  status_o
);
  logic [SL_W-1:0] lo_bound, hi_bound;
  logic            cmp_en, clr_req, hit;

  scw_regs #(.DATA_W(DATA_W), .SL_W(SL_W)) u_regs (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .lo_bound_o (lo_bound),
    .hi_bound_o (hi_bound),
    .cmp_en_o   (cmp_en),
    .clr_req_o  (clr_req)
  );

  scw_compare #(.SL_W(SL_W)) u_compare (
    .scanline_i (scanline_i),
    .lo_bound_i (lo_bound),
    .hi_bound_i (hi_bound),
    .cmp_en_i   (cmp_en),
    .hit_o      (hit)
  );

  scw_event u_event (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .hit_i         (hit),
    .frame_start_i (frame_start_i),
    .clr_req_i     (clr_req),
    .event_o       (event_o),
    .status_o      (status_o)
  );

  // R6: an event only follows a sample taken with the enable set
  assert_gate_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    event_o |-> $past(cmp_en));

  // R7: an event only follows a sample with a non-empty window
  assert_order_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    event_o |-> $past(lo_bound <= hi_bound));

  // R3: an event only follows a sample inside the bounds
  assert_inside_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    event_o |-> ($past(scanline_i) >= $past(lo_bound) && $past(scanline_i) <= $past(hi_bound)));
endmodule

// File: tb/test_scanline_window_event.sv
module test_scanline_window_event;
  localparam int DATA_W = 32;
  localparam int SL_W   = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic              wr_en;
  logic [1:0]        wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [SL_W-1:0]   scanline;
  logic              frame_start;
  logic              event_o, status_o;

  always #2 clk = ~clk;

  scanline_window_event #(.DATA_W(DATA_W), .SL_W(SL_W)) i_scanline_window_event (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .scanline_i(scanline), .frame_start_i(frame_start), .event_o(event_o), .status_o(status_o)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [15:0] sl;
    logic        fs;
    logic        ev;
    logic        st;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd1, 32'd100,       16'd0,   1'b0, 1'b0, 1'b0, 8'd2},  // R2 upper = 100
    '{1'b1, 2'd0, 32'h8000_0062, 16'd0,   1'b0, 1'b0, 1'b0, 8'd2},  // R2 lower = 98, enable
    '{1'b0, 2'd0, 32'd0,         16'd97,  1'b0, 1'b0, 1'b0, 8'd3},  // R3 below window
    '{1'b0, 2'd0, 32'd0,         16'd98,  1'b0, 1'b1, 1'b1, 8'd3},  // R3 lower edge fires
    '{1'b0, 2'd0, 32'd0,         16'd99,  1'b0, 1'b0, 1'b1, 8'd4},  // R4 no refire
    '{1'b0, 2'd0, 32'd0,         16'd100, 1'b0, 1'b0, 1'b1, 8'd4},  // R4 no refire
    '{1'b0, 2'd0, 32'd0,         16'd101, 1'b1, 1'b0, 1'b1, 8'd5},  // R5 rearm outside
    '{1'b0, 2'd0, 32'd0,         16'd100, 1'b0, 1'b1, 1'b1, 8'd3},  // R3 upper edge fires
    '{1'b1, 2'd2, 32'd1,         16'd102, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 clear
    '{1'b0, 2'd0, 32'd0,         16'd99,  1'b1, 1'b1, 1'b1, 8'd5},  // R5 strobe with hit
    '{1'b1, 2'd2, 32'd0,         16'd120, 1'b0, 1'b0, 1'b1, 8'd8},  // R8 zero write no effect
    '{1'b1, 2'd2, 32'd1,         16'd120, 1'b1, 1'b0, 1'b0, 8'd8},  // R8 clear, rearm
    '{1'b1, 2'd3, 32'd0,         16'd50,  1'b0, 1'b0, 1'b0, 8'd10}, // R10 spare write
    '{1'b0, 2'd0, 32'd0,         16'd99,  1'b0, 1'b1, 1'b1, 8'd10}, // R10 window intact
    '{1'b1, 2'd0, 32'h0000_0062, 16'd120, 1'b1, 1'b0, 1'b1, 8'd6},  // R6 disable
    '{1'b0, 2'd0, 32'd0,         16'd99,  1'b0, 1'b0, 1'b1, 8'd6},  // R6 no event
    '{1'b1, 2'd0, 32'h8000_006E, 16'd105, 1'b0, 1'b0, 1'b1, 8'd7},  // R7 lower 110 > upper
    '{1'b0, 2'd0, 32'd0,         16'd100, 1'b0, 1'b0, 1'b1, 8'd7},  // R7 empty window
    '{1'b1, 2'd1, 32'd120,       16'd115, 1'b0, 1'b0, 1'b1, 8'd11}, // R11 old upper used
    '{1'b0, 2'd0, 32'd0,         16'd115, 1'b0, 1'b1, 1'b1, 8'd11}, // R11 new upper used
    '{1'b1, 2'd2, 32'd1,         16'd115, 1'b1, 1'b1, 1'b1, 8'd9},  // R9 set beats clear
    '{1'b1, 2'd2, 32'd1,         16'd0,   1'b0, 1'b0, 1'b0, 8'd9}   // R9 then clear alone
  };

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; scanline = '0; frame_start = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    idle_inputs();
    repeat (3) step();
    rst = 1'b0;
    // R1: outputs quiet and comparison disabled after reset
    check("R1", "event after reset", event_o, 1'b0);
    check("R1", "status after reset", status_o, 1'b0);
    step();
    check("R1", "event at scanline 0 with zero registers", event_o, 1'b0);

    for (int i = 0; i < NV; i++) begin
      wr_en       = VEC[i].wr;
      wr_addr     = VEC[i].addr;
      wr_data     = VEC[i].data;
      scanline    = VEC[i].sl;
      frame_start = VEC[i].fs;
      step();
      check($sformatf("R%0d", VEC[i].rq), $sformatf("event vec %0d", i), event_o, VEC[i].ev);
      check($sformatf("R%0d", VEC[i].rq), $sformatf("status vec %0d", i), status_o, VEC[i].st);
    end
    idle_inputs();
    step();
    check("R3", "event is one cycle wide", event_o, 1'b0);

    // R4: long dwell inside a freshly enabled window fires once
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h8000_0010; step();
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'd30; frame_start = 1'b1; step();
    idle_inputs();
    scanline = 16'd20;
    step();
    check("R4", "first sample in window", event_o, 1'b1);
    for (int k = 0; k < 10; k++) begin
      scanline = 16'(21 + k);
      step();
      check("R4", "dwell in window", event_o, 1'b0);
    end

    // R1: mid-run reset clears registers, so a former window no longer fires
    rst = 1'b1; step();
    rst = 1'b0;
    check("R1", "status cleared by reset", status_o, 1'b0);
    scanline = 16'd0; frame_start = 1'b1; step();
    check("R1", "no event with cleared registers", event_o, 1'b0);
    scanline = 16'd20; frame_start = 1'b0; step();
    check("R1", "old window forgotten", event_o, 1'b0);

    finish_run();
  end
endmodule